// File: doc/BRIEF.md
# Sixteen-Bit I/O Port with Two Masked Interrupt Lines

This block is a general-purpose I/O port of sixteen bits that sits on a simple register bus. Software programs each pin as level or edge sensitive, chooses one edge or both, picks the active sense, and decides whether the pin's level is captured into the data register at all. A captured pin that meets its trigger condition raises an event. Each event is routed through two independent mask registers to two separate interrupt request outputs, so one pin can reach two handlers.

The data register and both masks have three extra alias addresses each. One clears the bits written as ones, one sets them and one inverts them. Reads from any alias return the register behind it. External pins pass through a two-flop synchronizer before they are captured or evaluated. The top bit of the port has no pin and changes only through bus writes.

Top module: `gpio_port_irq`

## Requirements
- R1: All registers reset to zero and both interrupt outputs are low after reset.
- R2: A legal write to a plain register replaces it whole. The offsets are 4 times the slot index: 0x00 data, 0x10 mask A, 0x20 mask B, 0x30 direction, 0x34 polarity, 0x38 edge select, 0x3C both-edge select, 0x40 input enable.
- R3: The alias offsets are base+0x04 (clear), base+0x08 (set) and base+0x0C (toggle), for the bases 0x00, 0x10 and 0x20. Clear removes every bit that is 1 in the written value, set ORs the value in, and toggle XORs it in.
- R4: A read returns the combinational value of the addressed register. A read at any alias returns its base register.
- R5: An access is legal only when the size code is 1 (16 bits; 0 is byte, 2 is 32-bit), the offset is a multiple of 4, and the offset is below 0x44. Any other access raises bus_err in the same cycle and changes no register.
- R6: Pin i (0 to 14) is copied into data bit i only while bit i is set in both direction and input enable. The copy lands on the third rising edge after the pin changes. Otherwise the pin changes nothing. Bit 15 changes only through writes.
- R7: With edge select 0, a captured pin raises an event in every cycle in which its synchronized level differs from its polarity bit: polarity 0 is active high, polarity 1 is active low.
- R8: With edge select 1, both-edge 1 triggers on any change. With both-edge 0, polarity 0 triggers on a rising edge only and polarity 1 on a falling edge only.
- R9: irq_a goes high for exactly one cycle when any event in a cycle meets a set mask A bit. irq_b does the same for mask B, independently. For an edge, the pulse appears at the third rising edge after the pin change.
- R10: In a cycle where a legal write to any data address coincides with a pin capture, the written result wins for the whole register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 7 | Byte offset in the port window |
| bus_size | input | 2 | Access size code (1 = 16 bit) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| bus_err | output | 1 | Illegal access flag, combinational |
| pin_in | input | 15 | Asynchronous pin levels |
| irq_a | output | 1 | Interrupt request through mask A |
| irq_b | output | 1 | Interrupt request through mask B |

## Verification
A bus write to the data register and a pin capture can land on the same clock edge. The bench holds a captured pin high and writes zero to the data register. It then reads the register in the cycle right after the write and expects the written zero, not the pin level. One cycle later it expects the pin level to be back in the register, which shows that the capture was deferred and not lost.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   // number of 16-bit slots in the register window
   localparam int unsigned REG_SLOTS = 17;
   // the only legal access size code
   localparam logic [1:0] SIZE_HALF = 2'd1;

   // slot order decides the decode: slots 0..11 form three aliased groups
   typedef enum logic [4:0] {
      IX_DATA = 5'd0, IX_DATA_CLR, IX_DATA_SET, IX_DATA_TGL,
      IX_MA, IX_MA_CLR, IX_MA_SET, IX_MA_TGL,
      IX_MB, IX_MB_CLR, IX_MB_SET, IX_MB_TGL,
      IX_DIR, IX_POL, IX_EDG, IX_BOTH, IX_INEN
   } reg_ix_e;

   typedef enum logic [1:0] {
      OP_LOAD = 2'd0, OP_CLR = 2'd1, OP_SET = 2'd2, OP_TGL = 2'd3
   } upd_op_e;

   localparam int unsigned ALIAS_GROUPS = 3;
   localparam int unsigned CFG_REGS     = 5;
   localparam int unsigned CFG_BASE     = 12;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int N      = 15,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (STAGES < 1) begin : g_bad
      $error("gpio_port_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0][N-1:0] st;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
         if (!rst_n) st <= '0;
         else        st <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk) begin
         if (!rst_n) st <= '0;
         else        st <= {st[STAGES-2:0], d};
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int W      = 16,
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [W-1:0]      bus_wdata,
   output logic [W-1:0]      bus_rdata,
   output logic              bus_err,
   input  logic [W-1:0]      cap_mask,
   input  logic [W-1:0]      cap_val,
   output logic [W-1:0]      data_q,
   output logic [W-1:0]      mask_a_q,
   output logic [W-1:0]      mask_b_q,
   output logic [W-1:0]      dir_q,
   output logic [W-1:0]      pol_q,
   output logic [W-1:0]      edg_q,
   output logic [W-1:0]      both_q,
   output logic [W-1:0]      inen_q
);
   localparam int WORD_W = ADDR_W - 2;
   localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(REG_SLOTS - 1);

   if (ADDR_W < 7) begin : g_bad_addr
      $error("gpio_port_regs: ADDR_W too small for the register window");
   end

   logic [WORD_W-1:0] word;
   logic [4:0]        ix;
   logic              legal;
   logic              wr_hit;

   assign word   = bus_addr[ADDR_W-1:2];
   assign ix     = word[4:0];
   assign legal  = (bus_size == SIZE_HALF) && (bus_addr[1:0] == 2'b00)
                   && (word <= LAST_WORD);
   assign bus_err = bus_en && !legal;
   assign wr_hit  = bus_en && bus_we && legal;

   function automatic logic [W-1:0] apply_op(input logic [W-1:0] cur,
                                             input logic [W-1:0] v,
                                             input upd_op_e      op);
      case (op)
         OP_LOAD: apply_op = v;
         OP_CLR:  apply_op = cur & ~v;
         OP_SET:  apply_op = cur | v;
         default: apply_op = cur ^ v;
      endcase
   endfunction

   logic [ALIAS_GROUPS-1:0][W-1:0] alias_v;
   logic [CFG_REGS-1:0][W-1:0]     cfg_v;

   // aliased groups: data, mask A, mask B
   for (genvar g = 0; g < ALIAS_GROUPS; g++) begin : g_alias
      logic         hit;
      logic [W-1:0] q;
      assign hit = wr_hit && (ix[4:2] == 3'(g));
      if (g == 0) begin : g_data
         // a bus write to the data group blocks capture for that cycle
         always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= apply_op(q, bus_wdata, upd_op_e'(ix[1:0]));
            else          q <= (q & ~cap_mask) | (cap_val & cap_mask);
         end
      end else begin : g_mask
         always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= apply_op(q, bus_wdata, upd_op_e'(ix[1:0]));
         end
      end
      assign alias_v[g] = q;
   end

   // plain configuration registers
   for (genvar k = 0; k < CFG_REGS; k++) begin : g_cfg
      logic         hit;
      logic [W-1:0] q;
      assign hit = wr_hit && (ix == 5'(CFG_BASE + k));
      always_ff @(posedge clk) begin
         if (!rst_n)   q <= '0;
         else if (hit) q <= bus_wdata;
      end
      assign cfg_v[k] = q;
   end

   logic [2:0] cfg_ix;
   assign cfg_ix = 3'(ix - 5'(CFG_BASE));

   always_comb begin
      bus_rdata = '0;
      if (legal) begin
         if (ix < 5'(CFG_BASE)) bus_rdata = alias_v[ix[3:2]];
         else                   bus_rdata = cfg_v[cfg_ix];
      end
   end

   assign data_q   = alias_v[0];
   assign mask_a_q = alias_v[1];
   assign mask_b_q = alias_v[2];
   assign dir_q    = cfg_v[0];
   assign pol_q    = cfg_v[1];
   assign edg_q    = cfg_v[2];
   assign both_q   = cfg_v[3];
   assign inen_q   = cfg_v[4];
endmodule

// File: rtl/gpio_port_evt.sv
module gpio_port_evt #(
   parameter int PINS = 15
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] lvl,
   input  logic [PINS-1:0] cap_en,
   input  logic [PINS-1:0] pol,
   input  logic [PINS-1:0] edg,
   input  logic [PINS-1:0] both,
   output logic [PINS-1:0] evt
);
   logic [PINS-1:0] prev;

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   for (genvar i = 0; i < PINS; i++) begin : g_pin
      logic rise, fall, hit;
      assign rise = lvl[i] & ~prev[i];
      assign fall = ~lvl[i] & prev[i];
      always_comb begin
         if (!edg[i])      hit = (lvl[i] != pol[i]);
         else if (both[i]) hit = rise | fall;
         else if (pol[i])  hit = fall;
         else              hit = rise;
      end
      assign evt[i] = cap_en[i] & hit;
   end
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq #(
   parameter int W           = 16,
   parameter int PINS        = 15,
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [W-1:0]      bus_wdata,
   output logic [W-1:0]      bus_rdata,
   output logic              bus_err,
   input  logic [PINS-1:0]   pin_in,
   output logic              irq_a,
   output logic              irq_b
);
   localparam int PAD = W - PINS;

   if (PINS < 1 || PINS >= W) begin : g_bad_pins
      $error("gpio_port_irq: PINS must lie between 1 and W-1");
   end

   logic [W-1:0]    data_q, mask_a_q, mask_b_q, dir_q, pol_q, edg_q, both_q, inen_q;
   logic [W-1:0]    cap_mask, cap_val;
   logic [PINS-1:0] lvl, cap_en, evt;

   gpio_port_sync #(.N(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
   );

   assign cap_en   = dir_q[PINS-1:0] & inen_q[PINS-1:0];
   assign cap_mask = {{PAD{1'b0}}, cap_en};
   assign cap_val  = {{PAD{1'b0}}, lvl};

   gpio_port_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err),
      .cap_mask(cap_mask), .cap_val(cap_val),
      .data_q(data_q), .mask_a_q(mask_a_q), .mask_b_q(mask_b_q),
      .dir_q(dir_q), .pol_q(pol_q), .edg_q(edg_q), .both_q(both_q),
      .inen_q(inen_q)
   );

   gpio_port_evt #(.PINS(PINS)) u_evt (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .cap_en(cap_en),
      .pol(pol_q[PINS-1:0]), .edg(edg_q[PINS-1:0]),
      .both(both_q[PINS-1:0]), .evt(evt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_a <= 1'b0;
         irq_b <= 1'b0;
      end else begin
         irq_a <= |(evt & mask_a_q[PINS-1:0]);
         irq_b <= |(evt & mask_b_q[PINS-1:0]);
      end
   end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int W      = 16,
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [W-1:0]      bus_wdata,
   input logic [W-1:0]      bus_rdata,
   input logic              bus_err,
   input logic [W-1:0]      data_q,
   input logic [W-1:0]      mask_a_q,
   input logic [W-1:0]      cap_en,
   input logic              irq_a
);
   logic data_grp, data_wr;
   assign data_grp = (bus_addr[ADDR_W-1:4] == '0);
   assign data_wr  = bus_en && bus_we && !bus_err && data_grp;

   // R5: an illegal write leaves mask A untouched
   a_r5_bad_write_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && bus_err) |=> (mask_a_q == $past(mask_a_q)));

   // R5: the error flag only accompanies an access
   a_r5_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> bus_en);

   // R3: the mask A set alias ORs the written value in
   a_r3_set_alias_ors: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && !bus_err && bus_addr == ADDR_W'(7'h18))
      |=> (mask_a_q == ($past(mask_a_q) | $past(bus_wdata))));

   // R4: every data alias reads the data register
   a_r4_alias_reads_base: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && !bus_err && data_grp) |-> (bus_rdata == data_q));

   // R6: with no capturing pin and no data write, data holds
   a_r6_idle_pins_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
      (!data_wr && cap_en == '0) |=> (data_q == $past(data_q)));

   // R9: a pulse on irq_a needs some mask A bit in the cycle before
   a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
      irq_a |-> ($past(mask_a_q) != '0));
endmodule

bind gpio_port_irq gpio_port_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .bus_err(bus_err), .data_q(data_q), .mask_a_q(mask_a_q),
   .cap_en(dir_q & inen_q), .irq_a(irq_a)
);

// File: tb/sim_gpio_port_irq.sv
module sim_gpio_port_irq;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [6:0]  wa;
      logic [15:0] wd;
      logic [6:0]  ra;
      logic [15:0] ex;
      logic [7:0]  rq;
   } vec_t;

   // write wa=wd, then read ra and expect ex
   localparam vec_t VECS [12] = '{
      '{7'h10, 16'hF0F0, 7'h10, 16'hF0F0, 8'd2},  // R2 mask A load
      '{7'h14, 16'h00F0, 7'h18, 16'hF000, 8'd3},  // R3 clear, R4 read via set alias
      '{7'h18, 16'h000F, 7'h1C, 16'hF00F, 8'd3},  // R3 set
      '{7'h1C, 16'hFF00, 7'h10, 16'h0F0F, 8'd3},  // R3 toggle
      '{7'h20, 16'h1234, 7'h24, 16'h1234, 8'd4},  // R4 mask B via clear alias
      '{7'h2C, 16'hFFFF, 7'h20, 16'hEDCB, 8'd3},  // R3 mask B toggle
      '{7'h00, 16'hA5A5, 7'h04, 16'hA5A5, 8'd2},  // R2 data load
      '{7'h04, 16'h0005, 7'h00, 16'hA5A0, 8'd3},  // R3 data clear
      '{7'h08, 16'h8001, 7'h0C, 16'hA5A1, 8'd3},  // R3 data set
      '{7'h0C, 16'hFFFF, 7'h00, 16'h5A5E, 8'd3},  // R3 data toggle
      '{7'h34, 16'hBEEF, 7'h34, 16'hBEEF, 8'd2},  // R2 polarity
      '{7'h40, 16'h0001, 7'h40, 16'h0001, 8'd2}   // R2 input enable
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [1:0]  bus_size = 2'd1;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_err;
   logic [14:0] pin_in = '0;
   logic        irq_a, irq_b;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] rd;
   logic        er;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_port_irq u0 (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err), .pin_in(pin_in),
      .irq_a(irq_a), .irq_b(irq_b)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [6:0] a, input logic [15:0] d, input logic [1:0] sz);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
      #1 er = bus_err;
      @(posedge clk); #1;
      bus_en = 1'b0; bus_we = 1'b0; bus_size = 2'd1;
   endtask

   task automatic rdreg(input logic [6:0] a, input logic [1:0] sz);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
      #1 rd = bus_rdata; er = bus_err;
      bus_en = 1'b0; bus_size = 2'd1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      rdreg(7'h00, 2'd1); check("R1 data", rd, 16'h0);
      rdreg(7'h10, 2'd1); check("R1 maskA", rd, 16'h0);
      rdreg(7'h30, 2'd1); check("R1 dir", rd, 16'h0);
      check("R1 irq", {14'h0, irq_a, irq_b}, 16'h0);

      for (int i = 0; i < 12; i++) begin
         wr(VECS[i].wa, VECS[i].wd, 2'd1);
         rdreg(VECS[i].ra, 2'd1);
         check($sformatf("R%0d vec%0d", VECS[i].rq, i), rd, VECS[i].ex);
      end

      // R5 illegal accesses
      wr(7'h20, 16'hFFFF, 2'd0);
      check("R5 err byte", {15'h0, er}, 16'h1);
      rdreg(7'h20, 2'd1); check("R5 maskB kept", rd, 16'hEDCB);
      wr(7'h44, 16'hFFFF, 2'd1);
      check("R5 err range", {15'h0, er}, 16'h1);
      rdreg(7'h02, 2'd1); check("R5 err misaligned", {15'h0, er}, 16'h1);
      wr(7'h10, 16'h1111, 2'd2);
      rdreg(7'h10, 2'd1); check("R5 maskA kept", rd, 16'h0F0F);

      // quiet configuration
      wr(7'h10, 16'h0001, 2'd1);
      wr(7'h20, 16'h0000, 2'd1);
      wr(7'h34, 16'h0000, 2'd1);
      wr(7'h38, 16'h0001, 2'd1);
      wr(7'h40, 16'h0000, 2'd1);
      wr(7'h30, 16'h0001, 2'd1);
      wr(7'h00, 16'h0000, 2'd1);

      // R6 pin ignored without input enable
      pin_in[0] = 1'b1;
      step(4);
      rdreg(7'h00, 2'd1); check("R6 no capture", rd, 16'h0000);
      check("R6 no irq", {15'h0, irq_a}, 16'h0);

      // R6 capture enabled (prev already 1, edge mode: no event)
      wr(7'h40, 16'h0001, 2'd1);
      step(1);
      rdreg(7'h00, 2'd1); check("R6 capture", rd, 16'h0001);

      // R10 bus write beats capture in the same cycle
      wr(7'h00, 16'h0000, 2'd1);
      rdreg(7'h00, 2'd1); check("R10 write wins", rd, 16'h0000);
      step(1);
      rdreg(7'h00, 2'd1); check("R6 recapture", rd, 16'h0001);

      // R7 level mode, active high, pin held high
      wr(7'h38, 16'h0000, 2'd1);
      step(1);
      check("R7 level high", {14'h0, irq_a, irq_b}, 16'h2);
      step(1);
      check("R7 level held", {15'h0, irq_a}, 16'h1);
      wr(7'h34, 16'h0001, 2'd1);
      step(1);
      check("R7 inactive", {15'h0, irq_a}, 16'h0);
      pin_in[0] = 1'b0;
      step(3);
      check("R7 active low", {15'h0, irq_a}, 16'h1);

      // R8 edge, single edge, rising
      wr(7'h34, 16'h0000, 2'd1);
      wr(7'h38, 16'h0001, 2'd1);
      step(2);
      check("R8 edge idle", {15'h0, irq_a}, 16'h0);
      pin_in[0] = 1'b1;
      step(3); check("R8 rise", {15'h0, irq_a}, 16'h1);
      step(1); check("R9 one-cycle pulse", {15'h0, irq_a}, 16'h0);
      pin_in[0] = 1'b0;
      step(3); check("R8 fall ignored", {15'h0, irq_a}, 16'h0);

      // R8 both edges
      wr(7'h3C, 16'h0001, 2'd1);
      pin_in[0] = 1'b1;
      step(3); check("R8 both rise", {15'h0, irq_a}, 16'h1);
      pin_in[0] = 1'b0;
      step(3); check("R8 both fall", {15'h0, irq_a}, 16'h1);

      // R8 single falling edge
      wr(7'h3C, 16'h0000, 2'd1);
      wr(7'h34, 16'h0001, 2'd1);
      pin_in[0] = 1'b1;
      step(3); check("R8 rise ignored", {15'h0, irq_a}, 16'h0);
      pin_in[0] = 1'b0;
      step(3); check("R8 falling", {15'h0, irq_a}, 16'h1);

      // R9 mask B only
      wr(7'h10, 16'h0000, 2'd1);
      wr(7'h20, 16'h0001, 2'd1);
      wr(7'h34, 16'h0000, 2'd1);
      pin_in[0] = 1'b1;
      step(3); check("R9 irq_b only", {14'h0, irq_a, irq_b}, 16'h1);
      step(1); check("R9 irq_b ends", {14'h0, irq_a, irq_b}, 16'h0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule